// File: doc/BRIEF.md
# Serial Configuration Header Checker

This block watches a bit-serial configuration stream and validates the fixed 40-bit header that opens it. It takes one bit per clock edge on which a qualifier input is high. The header is made of a run of sync ones, a four-bit code, a 24-bit length count and a run of trailing ones. The length count is assembled most-significant bit first. It is published on a 24-bit output at the moment the whole header has been accepted.

Each clock, the block also copies its serial input to a serial output one clock later. A downstream device chained behind this one therefore sees the same stream with a fixed one-cycle lag. When a fixed field is violated, the block raises a sticky error flag and stops parsing. A synchronous restart input, or reset, returns it to the hunting state. After a good header it ignores further bits until restart.

Top module: `cfg_hdr_check`

## Requirements
- R1: After reset, hdr_ok, hdr_err, echo_out and len_out are all 0.
- R2: A stream of eight 1 bits, then the code bits 0,0,1,0 in that order, then 24 length bits sent most-significant first, then four 1 bits, all taken on edges with bit_valid high, makes hdr_ok high for exactly one cycle. That cycle is the one after the edge that took the fortieth bit, and len_out holds the length from that cycle on.
- R3: Extra 1 bits after the first eight and before the first code bit are accepted as idle fill; the header is still recognised.
- R4: A 0 received before eight 1 bits have been seen raises hdr_err in the cycle after that bit.
- R5: A code bit differing from 0,0,1,0 raises hdr_err in the cycle after that bit.
- R6: A 0 among the four trailing bits raises hdr_err in the cycle after that bit.
- R7: hdr_err stays high, and incoming bits have no effect, until restart is sampled high. In the cycle after that, hdr_err is low and a fresh header is parsed normally.
- R8: On every cycle after reset, echo_out equals the value bit_in had at the previous clock edge.
- R9: Edges with bit_valid low do not advance parsing; a header with idle cycles interleaved is recognised with the correct length.
- R10: After a header is accepted, further bits neither pulse hdr_ok again nor change len_out until restart; len_out changes only in a cycle where hdr_ok is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Synchronous return to the header hunt; clears the error flag |
| bit_valid | input | 1 | Qualifies bit_in on this edge |
| bit_in | input | 1 | Serial configuration data |
| echo_out | output | 1 | bit_in delayed by one clock |
| hdr_ok | output | 1 | One-cycle pulse when a full header has been accepted |
| hdr_err | output | 1 | Sticky flag for a fixed-field violation |
| len_out | output | 24 | Length count of the last accepted header |

## Verification
A parser that loses its position in the header is seen at the ports as a wrong outcome. Either hdr_ok fires early, late or not at all, or hdr_err appears on a legal bit. The mismatch shows one cycle after the bit at which the position went wrong, or at the latest one cycle after the fortieth bit. A shifted or mis-ordered length shows directly on len_out in the hdr_ok cycle. A wrong echo path shows on the very next cycle, so it is compared on every cycle of the run.

// File: rtl/cfg_hdr_check.sv
module cfg_hdr_check #(
  parameter int SYNC_ONES = 8,
  parameter int CODE_W = 4,
  parameter logic [CODE_W-1:0] CODE_VAL = 4'b0010,
  parameter int LEN_W = 24,
  parameter int TAIL_ONES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             bit_valid,
  input  logic             bit_in,
  output logic             echo_out,
  output logic             hdr_ok,
  output logic             hdr_err,
  output logic [LEN_W-1:0] len_out
);
  localparam int CW = $clog2(SYNC_ONES + LEN_W + CODE_W + TAIL_ONES + 1);

  typedef enum logic [2:0] {S_SYNC, S_CODE, S_LEN, S_TAIL, S_DONE, S_ERR} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [LEN_W-1:0] shreg;
  logic           code_bit;

  assign code_bit = CODE_VAL[CODE_W-1-int'(cnt)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_SYNC;
      cnt <= '0;
      shreg <= '0;
      len_out <= '0;
      echo_out <= 1'b0;
      hdr_ok <= 1'b0;
      hdr_err <= 1'b0;
    end else begin
      echo_out <= bit_in;
      hdr_ok <= 1'b0;
      if (restart) begin
        st <= S_SYNC;
        cnt <= '0;
        hdr_err <= 1'b0;
      end else if (bit_valid) begin
        case (st)
          S_SYNC:
            if (bit_in) begin
              if (cnt < CW'(SYNC_ONES)) cnt <= cnt + 1'b1;
            end else if (cnt == CW'(SYNC_ONES) && CODE_VAL[CODE_W-1] == 1'b0) begin
              st <= S_CODE;
              cnt <= CW'(1);
            end else begin
              st <= S_ERR;
              hdr_err <= 1'b1;
            end
          S_CODE:
            if (bit_in == code_bit) begin
              if (cnt == CW'(CODE_W - 1)) begin
                st <= S_LEN;
                cnt <= '0;
              end else cnt <= cnt + 1'b1;
            end else begin
              st <= S_ERR;
              hdr_err <= 1'b1;
            end
          S_LEN: begin
            shreg <= {shreg[LEN_W-2:0], bit_in};
            if (cnt == CW'(LEN_W - 1)) begin
              st <= S_TAIL;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end
          S_TAIL:
            if (bit_in) begin
              if (cnt == CW'(TAIL_ONES - 1)) begin
                st <= S_DONE;
                cnt <= '0;
                hdr_ok <= 1'b1;
                len_out <= shreg;
              end else cnt <= cnt + 1'b1;
            end else begin
              st <= S_ERR;
              hdr_err <= 1'b1;
            end
          default: ;
        endcase
      end
    end
  end

  assert_echo_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> echo_out == $past(bit_in));
  assert_ok_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_ok |=> !hdr_ok);
  assert_ok_err_apart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_ok && hdr_err));
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err && !restart |=> hdr_err);
  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !hdr_err);
  assert_idle_no_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid && !restart |=> $stable(hdr_err));
  assert_idle_no_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> !hdr_ok);
  assert_len_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(len_out) |-> hdr_ok);
endmodule

// File: tb/cfg_hdr_check_tb_top.sv
module cfg_hdr_check_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, restart = 0, bit_valid = 0, bit_in = 0;
  logic echo_out, hdr_ok, hdr_err;
  logic [23:0] len_out;

  int total = 0, bad = 0;
  logic [25:0] expq[$];
  logic prev_err = 0;
  logic mon_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_hdr_check dut_i (
    .clk(clk), .rst_n(rst_n), .restart(restart), .bit_valid(bit_valid),
    .bit_in(bit_in), .echo_out(echo_out), .hdr_ok(hdr_ok), .hdr_err(hdr_err),
    .len_out(len_out));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: echo each cycle, events popped from the scoreboard queue
  always @(negedge clk) begin
    if (mon_on) begin
      check("R8 echo", {31'd0, echo_out}, {31'd0, bit_in});
      if (hdr_ok) begin
        if (expq.size() == 0) check("R10 unexpected ok", 32'd1, 32'd0);
        else begin
          logic [25:0] e;
          e = expq.pop_front();
          check("R2 ok event", {30'd0, e[25:24]}, 32'd1);
          check("R2 length", {8'd0, len_out}, {8'd0, e[23:0]});
        end
      end
      if (hdr_err && !prev_err) begin
        if (expq.size() == 0) check("R7 unexpected err", 32'd1, 32'd0);
        else begin
          logic [25:0] e;
          e = expq.pop_front();
          check("R4 R5 R6 err event", {30'd0, e[25:24]}, 32'd2);
        end
      end
    end
    prev_err = hdr_err;
  end

  task automatic send_bit(input logic b);
    @(negedge clk); #1;
    bit_valid = 1; bit_in = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      bit_valid = 0; bit_in = i[0];
    end
  endtask

  task automatic do_restart();
    @(negedge clk); #1;
    bit_valid = 0; restart = 1;
    @(negedge clk); #1;
    restart = 0;
  endtask

  // stall: insert an idle cycle before every bit index divisible by 3
  task automatic send_hdr(input logic [23:0] len, input int extra, input bit stall,
                          input logic [39:0] flip, input logic [1:0] kind);
    logic [39:0] h;
    h = {8'hFF, 4'b0010, len, 4'hF} ^ flip;
    if (kind != 0) expq.push_back({kind, len});
    for (int i = 0; i < extra; i++) send_bit(1'b1);
    for (int i = 39; i >= 0; i--) begin
      if (stall && (i % 3 == 0)) idle(1);
      send_bit(h[i]);
    end
    idle(3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ok", {31'd0, hdr_ok}, 0);
    check("R1 err", {31'd0, hdr_err}, 0);
    check("R1 echo", {31'd0, echo_out}, 0);
    check("R1 len", {8'd0, len_out}, 0);
    #1 rst_n = 1;
    @(negedge clk); mon_on = 1;

    send_hdr(24'hA5C3F1, 0, 0, 40'd0, 2'd1);                 // R2
    do_restart();
    send_hdr(24'h000001, 5, 0, 40'd0, 2'd1);                 // R3
    do_restart();
    send_hdr(24'hFFFFFF, 0, 1, 40'd0, 2'd1);                 // R9
    send_hdr(24'h000000, 0, 0, 40'd0, 2'd0);                 // R10 ignored
    check("R10 len held", {8'd0, len_out}, 32'hFFFFFF);
    do_restart();
    send_hdr(24'h123456, 0, 0, 40'h10_0000_0000, 2'd2);      // R4: bit 4 is 0
    send_hdr(24'h654321, 0, 0, 40'd0, 2'd0);                 // R7 ignored
    check("R7 err held", {31'd0, hdr_err}, 1);
    do_restart();
    check("R7 err cleared", {31'd0, hdr_err}, 0);
    send_hdr(24'h0F0F0F, 3, 0, 40'h00_1000_0000, 2'd2);      // R5: code 0011
    do_restart();
    send_hdr(24'h777777, 0, 0, 40'h00_0000_0002, 2'd2);      // R6: tail 1101
    do_restart();
    send_hdr(24'h800000, 0, 1, 40'd0, 2'd1);                 // R7 resume
    check("R10 final len", {8'd0, len_out}, 32'h800000);
    check("R2 queue drained", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule